// File: doc/BRIEF.md
# External Interrupt Capture and Code

This block collects the external interrupt sources of a processor: six external signal lines, a console interrupt key and the underflow of an interval timer. Each source has its own sticky latch. A single external mask latch decides whether the latched sources are passed on as one external request to the processor's interrupt logic. The latches are presented as a 16-bit interrupt code for the old status word. Reading them onto the status bus clears them.

The block also contains the interval timer. This is a 32-bit signed counter that software can load. Each line-frequency tick lowers it by one while the processor is not in the stopped state. The timer source is raised when the counter passes from zero to a negative value. A separate strobe reads the channel-request group. During that read, a summary bit reports whether any external latch is set.

Top module: `ext_irq_unit`

## Requirements
- R1: A source latch sets at the clock edge where its input is 1 and holds its value until a clearing read.
- R2: `irq_code` holds the latches in fixed positions. External line input `ext_line[i]` (signal i+2) is at bit 5-i, the console key at bit 6 and the timer source at bit 7. Bits 15..8 are always zero.
- R3: On every cycle with `psw_load` high, the mask latch takes the value of `psw_mask_bit`. With `psw_load` low it holds.
- R4: `ext_req` is 1 exactly when the mask latch is 1 and at least one source latch is set. Latches that are masked stay set.
- R5: A cycle with `rd_latch` high clears every source latch at the following edge.
- R6: A source whose input is 1 in the same cycle as `rd_latch` stays set after that edge.
- R7: `sum_bit7` is 1 while `rd_chan` is high and any source latch is set, and is 0 otherwise. `rd_chan` leaves the latches unchanged.
- R8: `tmr_load` writes `tmr_load_val` into the timer at the next edge. It takes priority over a tick in the same cycle.
- R9: A tick that takes the timer from 0 to -1 sets the timer source latch at that same edge. Further ticks while the timer is negative do not set it again.
- R10: The timer does not move on a tick while `stopped` is high. With `stopped` low, each tick lowers it by one.
- R11: After reset all latches, the mask and the timer are zero, and both `ext_req` and `sum_bit7` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_line | input | 6 | External signal lines; bit i is signal i+2 |
| console_key | input | 1 | Console interrupt key pulse |
| psw_load | input | 1 | Status-word load strobe |
| psw_mask_bit | input | 1 | External mask bit of the loaded status word |
| rd_latch | input | 1 | Read latch states onto the bus (clears them) |
| rd_chan | input | 1 | Read the channel-request group |
| stopped | input | 1 | Processor is in the stopped state |
| line_tick | input | 1 | Line-frequency tick, one cycle wide |
| tmr_load | input | 1 | Load strobe for the interval timer |
| tmr_load_val | input | 32 | Value loaded into the timer |
| ext_req | output | 1 | Unmasked external interrupt request |
| sum_bit7 | output | 1 | Summary bit for the channel-request read |
| irq_code | output | 16 | Interrupt code built from the latches |
| tmr_value | output | 32 | Current interval timer value |

## Verification
Single lines are pulsed one at a time to tell a correct bit position in the code apart from a swapped or shifted layout. The key and timer sources are pulsed on their own for the same reason. The mask is toggled while a latch is held, which separates gating the request from clearing the latch. Clearing reads are run both with all sources idle and with one source active in the same cycle. The timer is walked from a small positive value through zero and on into negative values, with stopped ticks and load-versus-tick collisions placed between the steps. This shows whether it fires on the crossing only, exactly once, and never while stopped.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned NUM_LINES = 6;
  localparam int unsigned SRC_N     = NUM_LINES + 2;
  localparam int unsigned CODE_W    = 16;
  localparam int unsigned TMR_W     = 32;
  localparam int unsigned KEY_POS   = NUM_LINES;
  localparam int unsigned TMR_POS   = NUM_LINES + 1;

  // bit position of external line i inside the code (highest line lowest)
  function automatic int unsigned line_pos(input int unsigned i);
    return NUM_LINES - 1 - i;
  endfunction

  function automatic logic [TMR_W-1:0] tmr_dec(input logic [TMR_W-1:0] v);
    return v - 1'b1;
  endfunction

  // non-negative before, negative after
  function automatic logic tmr_crosses(input logic [TMR_W-1:0] old_v,
                                       input logic [TMR_W-1:0] new_v);
    return !old_v[TMR_W-1] && new_v[TMR_W-1];
  endfunction
endpackage

// File: rtl/ext_src_latch.sv
module ext_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end

  assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/ext_interval_timer.sv
module ext_interval_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  input  logic         stop_i,
  output logic [W-1:0] value_o,
  output logic         fire_o
);
  logic         dec_en;
  logic [W-1:0] dec_val;

  assign dec_en  = tick_i & ~stop_i & ~load_i;
  assign dec_val = value_o - 1'b1;
  assign fire_o  = dec_en & !value_o[W-1] & dec_val[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_o <= '0;
    else if (load_i) value_o <= load_val_i;
    else if (dec_en) value_o <= dec_val;
  end

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (value_o == $past(load_val_i)));
  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> $stable(value_o));
  assert_fire_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> value_o[W-1]);
  assert_fire_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_line,
  input  logic                 console_key,
  input  logic                 psw_load,
  input  logic                 psw_mask_bit,
  input  logic                 rd_latch,
  input  logic                 rd_chan,
  input  logic                 stopped,
  input  logic                 line_tick,
  input  logic                 tmr_load,
  input  logic [TMR_W-1:0]     tmr_load_val,
  output logic                 ext_req,
  output logic                 sum_bit7,
  output logic [CODE_W-1:0]    irq_code,
  output logic [TMR_W-1:0]     tmr_value
);
  logic [SRC_N-1:0] src_set;
  logic [SRC_N-1:0] src_q;
  logic             tmr_fire;
  logic             mask_q;
  logic             any_src;

  ext_interval_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_load_val),
    .tick_i(line_tick), .stop_i(stopped), .value_o(tmr_value), .fire_o(tmr_fire)
  );

  always_comb begin
    src_set = '0;
    for (int unsigned i = 0; i < NUM_LINES; i++)
      src_set[line_pos(i)] = ext_line[i];
    src_set[KEY_POS] = console_key;
    src_set[TMR_POS] = tmr_fire;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    ext_src_latch u_latch (
      .clk(clk), .rst_n(rst_n), .set_i(src_set[g]), .clr_i(rd_latch), .q_o(src_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= 1'b0;
    else if (psw_load) mask_q <= psw_mask_bit;
  end

  assign any_src  = |src_q;
  assign ext_req  = mask_q & any_src;
  assign sum_bit7 = rd_chan & any_src;
  assign irq_code = {{(CODE_W-SRC_N){1'b0}}, src_q};

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    psw_load |=> (mask_q == $past(psw_mask_bit)));
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_load |=> $stable(mask_q));
  assert_timer_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_fire |=> src_q[TMR_POS]);
  assert_chan_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chan && !rd_latch) |=> ((src_q & $past(src_q)) == $past(src_q)));
endmodule

// File: tb/ext_irq_unit_test.sv
module ext_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ext_line = '0;
  logic        console_key = 1'b0, psw_load = 1'b0, psw_mask_bit = 1'b0;
  logic        rd_latch = 1'b0, rd_chan = 1'b0, stopped = 1'b0;
  logic        line_tick = 1'b0, tmr_load = 1'b0;
  logic [31:0] tmr_load_val = '0;
  logic        ext_req, sum_bit7;
  logic [15:0] irq_code;
  logic [31:0] tmr_value;

  ext_irq_unit uut (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] code;
    logic        req;
    logic        sum;
    logic [31:0] tmr;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  m_lat = '0;
  logic        m_mask = 1'b0;
  logic [31:0] m_tmr = '0;
  bit          done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts the post-edge view
  task automatic step(input logic [5:0] lines, input logic key, input logic pld, input logic pbit,
                      input logic rdl, input logic rdc, input logic stp, input logic tck,
                      input logic tld, input logic [31:0] tval, input string tag);
    exp_t e;
    logic fire;
    logic [7:0] setv;
    @(negedge clk);
    ext_line = lines; console_key = key; psw_load = pld; psw_mask_bit = pbit;
    rd_latch = rdl; rd_chan = rdc; stopped = stp; line_tick = tck;
    tmr_load = tld; tmr_load_val = tval;
    fire = tck && !stp && !tld && (m_tmr == 32'd0);
    for (int i = 0; i < 6; i++) setv[5-i] = lines[i];
    setv[6] = key;
    setv[7] = fire;
    m_lat = (rdl ? 8'h00 : m_lat) | setv;
    if (pld) m_mask = pbit;
    if (tld) m_tmr = tval;
    else if (tck && !stp) m_tmr = m_tmr - 32'd1;
    e.code = {8'h00, m_lat};
    e.req = m_mask && (m_lat != 0);
    e.sum = rdc && (m_lat != 0);
    e.tmr = m_tmr;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(6'b0, 0, 0, 0, 0, 0, 0, 0, 0, 32'd0, tag);
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() != 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, "irq_code", {16'h0, irq_code}, {16'h0, e.code});
        chk(e.tag, "ext_req", {31'h0, ext_req}, {31'h0, e.req});
        chk(e.tag, "sum_bit7", {31'h0, sum_bit7}, {31'h0, e.sum});
        chk(e.tag, "tmr_value", tmr_value, e.tmr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11", "irq_code", {16'h0, irq_code}, 32'h0);
    chk("R11", "ext_req", {31'h0, ext_req}, 32'h0);
    chk("R11", "tmr_value", tmr_value, 32'h0);
    rst_n = 1'b1;
    idle("R11 after reset");
    // R1 R2: line 0 (signal 2) lands in code bit 5; masked so R4 no request
    step(6'b000001, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 line0");
    idle("R1 hold");
    step(6'b0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R3 mask on, R4 request");
    step(6'b0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 summary");
    idle("R7 no clear");
    step(6'b0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 clear");
    step(6'b100000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 line5");
    step(6'b0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5 clear with rd_chan");
    step(6'b0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 key");
    step(6'b000100, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R6 reassert during clear");
    step(6'b0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R4 masked held");
    idle("R4 masked still held");
    step(6'b0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R3 unmask");
    step(6'b0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 clear");
    // timer
    step(6'b0, 0, 0, 0, 0, 0, 0, 0, 1, 32'd2, "R8 load");
    step(6'b0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 tick");
    step(6'b0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R10 stopped");
    step(6'b0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 tick to zero");
    step(6'b0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 crossing");
    step(6'b0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 negative tick");
    step(6'b0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 clear timer");
    step(6'b0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 no refire");
    step(6'b0, 0, 0, 0, 0, 0, 0, 1, 1, 32'd0, "R8 load beats tick");
    step(6'b0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R10 stopped at zero");
    step(6'b0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 second crossing");
    step(6'b0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 timer summary");
    idle("end");
    @(posedge clk);
    #8;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule